// File: doc/BRIEF.md
# Deterministic Test Pattern Source

This block drives one data word per clock into a histogram engine, so that the engine's binning, counting and readout can be checked against distributions known in advance. A 3-bit mode input picks the pattern. Two value inputs, `val_a_i` and `val_b_i`, give the constants or the interval bounds that the pattern uses. All patterns are deterministic. The "uniform" patterns step through values in ascending order and do not scramble them. Over a whole number of periods, each value they reach therefore appears equally often.

Five patterns are available:
- A free-running ramp over every code.
- A fixed word.
- A ramp limited to a closed interval.
- A ramp over every code outside a closed interval.
- A two-word toggle.

The output is a register. A synchronous reset, or any change on the mode input, restarts the chosen pattern at its first value at the next clock edge. This gives every measurement window a known starting phase.

Top module: `tpg_pattern_gen`

## Requirements
- R1: With mode code 0 (ramp), the output starts at 0 after a restart, rises by one each clock, and wraps from 255 to 0.
- R2: With mode code 1 (fixed), the output equals `val_a_i` on every clock.
- R3: With mode code 2 (inside) and `val_a_i` <= `val_b_i`, the output starts at `val_a_i`, rises by one each clock up to and including `val_b_i`, and then returns to `val_a_i`.
- R4: With mode code 2 and `val_a_i` > `val_b_i`, the output holds at `val_a_i`.
- R5: With mode code 3 (outside), the output ascends through 0 .. `val_a_i`-1 and then `val_b_i`+1 .. 255, and then starts over. Codes from `val_a_i` to `val_b_i` never appear. When `val_a_i` > `val_b_i`, no code is excluded and the output is the full ramp from 0.
- R6: With mode code 3, `val_a_i` = 0 and `val_b_i` = 255, the output holds at 0.
- R7: With mode code 4 (toggle), the output is `val_a_i` on the first clock after a restart and then alternates between `val_b_i` and `val_a_i` on every clock.
- R8: A clock edge with `rst` high loads the first value of the mode present at that edge.
- R9: A clock edge at which the mode input differs from its value at the previous edge loads the first value of the new mode, without a reset.
- R10: Mode codes 5, 6 and 7 behave exactly like mode code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; restarts the pattern |
| mode_i | input | 3 | Pattern select: 0 ramp, 1 fixed, 2 inside, 3 outside, 4 toggle, 5-7 fixed |
| val_a_i | input | DATA_W (8) | Fixed word, toggle first word, or lower interval bound |
| val_b_i | input | DATA_W (8) | Toggle second word, or upper interval bound |
| data_o | output | DATA_W (8) | Registered pattern word |

## Verification
The assertions check the per-cycle laws on every cycle:
- Ramp increment with wraparound.
- The fixed word, which also covers the unlisted codes.
- Containment of the inside pattern within its bounds.
- Exclusion of the interval in the outside pattern, and the empty-set hold.
- The toggle changing value every cycle.
- The first value loaded on reset and on a mode change.

Only the bench's scenarios show the exact order of the sequences:
- The jump from `val_a_i`-1 to `val_b_i`+1.
- Where each pattern wraps.
- The inverted-bounds cases.
- The toggle's starting phase.
- Restarts between modes that happen with no reset.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_RAMP    = 3'd0,
      MODE_FIXED   = 3'd1,
      MODE_INSIDE  = 3'd2,
      MODE_OUTSIDE = 3'd3,
      MODE_TOGGLE  = 3'd4
   } tpg_mode_e;

endpackage

// File: rtl/tpg_restart_det.sv
// Remembers the mode seen at the previous edge and flags a restart
// whenever reset is high or the mode input has moved.
module tpg_restart_det #(
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] mode_i,
   output logic [MODE_W-1:0] prev_mode_o,
   output logic              restart_o
);

   logic [MODE_W-1:0] mode_q;

   always_ff @(posedge clk) begin
      mode_q <= mode_i;
   end

   assign prev_mode_o = mode_q;
   assign restart_o   = rst || (mode_i != mode_q);

endmodule

// File: rtl/tpg_inside_step.sv
// Successor function for the closed-interval ramp.
module tpg_inside_step #(
   parameter int W = 8
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic [W-1:0] first_o,
   output logic [W-1:0] next_o
);

   logic [W-1:0] inc;
   logic         inverted;
   logic         at_or_past_top;
   logic         below_floor;

   assign inc            = cur_i + 1'b1;
   assign inverted       = lo_i > hi_i;
   assign at_or_past_top = cur_i >= hi_i;
   assign below_floor    = cur_i < lo_i;

   // The ramp always begins at the lower bound; inverted bounds pin it there.
   assign first_o = lo_i;

   always_comb begin
      if (inverted || at_or_past_top || below_floor) begin
         next_o = lo_i;
      end else begin
         next_o = inc;
      end
   end

endmodule

// File: rtl/tpg_outside_step.sv
// Successor function for the ramp that skips a closed interval.
// Jumps over the excluded band in one step instead of walking through it.
module tpg_outside_step #(
   parameter int W = 8
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic [W-1:0] first_o,
   output logic [W-1:0] next_o,
   output logic         empty_o
);

   localparam logic [W-1:0] TOP  = {W{1'b1}};
   localparam logic [W-1:0] ZERO = '0;

   logic [W-1:0] inc;
   logic [W-1:0] above_band;
   logic         no_band;
   logic         inc_allowed;
   logic         band_hits_top;

   assign inc           = cur_i + 1'b1;
   assign above_band    = hi_i + 1'b1;
   assign no_band       = lo_i > hi_i;
   assign empty_o       = (lo_i == ZERO) && (hi_i == TOP);
   assign band_hits_top = hi_i == TOP;
   assign inc_allowed   = no_band || (inc < lo_i) || (inc > hi_i);

   always_comb begin
      if (empty_o) begin
         first_o = ZERO;
      end else if (lo_i != ZERO || no_band) begin
         first_o = ZERO;
      end else begin
         first_o = above_band;
      end
   end

   always_comb begin
      if (empty_o) begin
         next_o = ZERO;
      end else if (inc_allowed) begin
         next_o = inc;
      end else if (band_hits_top) begin
         next_o = first_o;
      end else begin
         next_o = above_band;
      end
   end

endmodule

// File: rtl/tpg_pattern_gen.sv
module tpg_pattern_gen #(
   parameter int DATA_W = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [tpg_pkg::MODE_W-1:0]  mode_i,
   input  logic [DATA_W-1:0]           val_a_i,
   input  logic [DATA_W-1:0]           val_b_i,
   output logic [DATA_W-1:0]           data_o
);

   import tpg_pkg::*;

   localparam logic [DATA_W-1:0] TOP  = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] ZERO = '0;

   // Elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_width
      $error("tpg_pattern_gen: DATA_W must be at least 2");
   end
   if (MODE_W < 3) begin : g_bad_mode_w
      $error("tpg_pattern_gen: mode field too narrow for five patterns");
   end

   // Restart detection
   logic [MODE_W-1:0] prev_mode;
   logic              restart;

   tpg_restart_det #(.MODE_W(MODE_W)) u_restart (
      .clk         (clk),
      .rst         (rst),
      .mode_i      (mode_i),
      .prev_mode_o (prev_mode),
      .restart_o   (restart)
   );

   // Interval successors
   logic [DATA_W-1:0] in_first, in_next;
   logic [DATA_W-1:0] out_first, out_next;
   logic              out_empty;

   tpg_inside_step #(.W(DATA_W)) u_inside (
      .cur_i   (data_o),
      .lo_i    (val_a_i),
      .hi_i    (val_b_i),
      .first_o (in_first),
      .next_o  (in_next)
   );

   tpg_outside_step #(.W(DATA_W)) u_outside (
      .cur_i   (data_o),
      .lo_i    (val_a_i),
      .hi_i    (val_b_i),
      .first_o (out_first),
      .next_o  (out_next),
      .empty_o (out_empty)
   );

   // Toggle phase: high while the word on the output is val_a
   logic tog_q;

   logic [DATA_W-1:0] first_val;
   logic [DATA_W-1:0] step_val;
   logic [DATA_W-1:0] ramp_next;

   assign ramp_next = data_o + 1'b1;

   always_comb begin
      case (mode_i)
         MODE_RAMP: begin
            first_val = ZERO;
            step_val  = ramp_next;
         end
         MODE_INSIDE: begin
            first_val = in_first;
            step_val  = in_next;
         end
         MODE_OUTSIDE: begin
            first_val = out_first;
            step_val  = out_next;
         end
         MODE_TOGGLE: begin
            first_val = val_a_i;
            step_val  = tog_q ? val_b_i : val_a_i;
         end
         default: begin
            first_val = val_a_i;
            step_val  = val_a_i;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (restart) begin
         data_o <= first_val;
         tog_q  <= 1'b1;
      end else begin
         data_o <= step_val;
         tog_q  <= ~tog_q;
      end
   end

   // Assertions
   // R1
   ramp_incr_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_RAMP && prev_mode == MODE_RAMP)
      |=> data_o == $past(data_o) + 1'b1);

   // R2
   fixed_word_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_FIXED) |=> data_o == $past(val_a_i));

   // R3
   inside_bounds_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_INSIDE && val_a_i <= val_b_i)
      |=> (data_o >= $past(val_a_i) && data_o <= $past(val_b_i)));

   // R4
   inside_inverted_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_INSIDE && val_a_i > val_b_i)
      |=> data_o == $past(val_a_i));

   // R5
   outside_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_OUTSIDE && !(val_a_i == ZERO && val_b_i == TOP))
      |=> ($past(val_a_i) > $past(val_b_i) || data_o < $past(val_a_i)
           || data_o > $past(val_b_i)));

   // R6
   outside_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_OUTSIDE && val_a_i == ZERO && val_b_i == TOP)
      |=> data_o == ZERO);

   // R7
   toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i == MODE_TOGGLE && prev_mode == MODE_TOGGLE
       && val_a_i != val_b_i && $stable(val_a_i) && $stable(val_b_i))
      |=> data_o != $past(data_o));

   // R8
   reset_ramp_chk: assert property (@(posedge clk)
      (rst && mode_i == MODE_RAMP) |=> data_o == ZERO);

   // R9
   switch_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i != prev_mode && mode_i == MODE_TOGGLE)
      |=> data_o == $past(val_a_i));

   // R10
   spare_code_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i > MODE_TOGGLE) |=> data_o == $past(val_a_i));

endmodule

// File: tb/tb_tpg_pattern_gen.sv
module tb_tpg_pattern_gen;

   localparam int NV = 14;
   localparam int NE = 6;

   // mode, a, b, then six expected words starting at the restart value
   localparam int VM [NV] = '{0, 1, 6, 7, 2, 2, 2, 3, 3, 3, 3, 4, 3, 2};
   localparam int VA [NV] = '{0, 90, 51, 9, 10, 12, 7, 2, 0, 3, 0, 17, 5, 254};
   localparam int VB [NV] = '{0, 0, 0, 200, 12, 10, 7, 253, 252, 255, 255, 34, 3, 255};
   localparam int VE [NV][NE] = '{
      '{0, 1, 2, 3, 4, 5},               // R1 ramp
      '{90, 90, 90, 90, 90, 90},         // R2 fixed
      '{51, 51, 51, 51, 51, 51},         // R10 code 6
      '{9, 9, 9, 9, 9, 9},               // R10 code 7
      '{10, 11, 12, 10, 11, 12},         // R3 inside
      '{12, 12, 12, 12, 12, 12},         // R4 inverted
      '{7, 7, 7, 7, 7, 7},               // R3 single point
      '{0, 1, 254, 255, 0, 1},           // R5 both sides
      '{253, 254, 255, 253, 254, 255},   // R5 band at bottom
      '{0, 1, 2, 0, 1, 2},               // R5 band at top
      '{0, 0, 0, 0, 0, 0},               // R6 empty set
      '{17, 34, 17, 34, 17, 34},         // R7 toggle
      '{0, 1, 2, 3, 4, 5},               // R5 inverted bounds
      '{254, 255, 254, 255, 254, 255}    // R3 wrap at top
   };

   logic       clk = 1'b0;
   logic       rst;
   logic [2:0] mode;
   logic [7:0] va;
   logic [7:0] vb;
   logic [7:0] dout;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   string vtag [NV];

   always #4 clk = ~clk;

   tpg_pattern_gen #(.DATA_W(8)) dut (
      .clk     (clk),
      .rst     (rst),
      .mode_i  (mode),
      .val_a_i (va),
      .val_b_i (vb),
      .data_o  (dout)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: data_o=%0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      vtag = '{"R1", "R2", "R10", "R10", "R3", "R4", "R3", "R5", "R5", "R5",
               "R6", "R7", "R5", "R3"};
      rst  = 1'b1;
      mode = 3'd0;
      va   = 8'd0;
      vb   = 8'd0;

      // Reset state, R8
      @(negedge clk);
      chk("R8", dout, 8'd0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         mode = 3'(VM[i]);
         va   = 8'(VA[i]);
         vb   = 8'(VB[i]);
         rst  = 1'b1;
         @(negedge clk);
         chk(vtag[i], dout, 8'(VE[i][0]));
         rst = 1'b0;
         for (int k = 1; k < NE; k++) begin
            @(negedge clk);
            chk(vtag[i], dout, 8'(VE[i][k]));
         end
      end

      // R1 full-range wrap
      mode = 3'd0;
      rst  = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 1; k <= 256; k++) begin
         @(negedge clk);
         if (k == 255) chk("R1", dout, 8'd255);
         if (k == 256) chk("R1", dout, 8'd0);
      end

      // R9 mode changes without reset
      @(negedge clk);
      chk("R1", dout, 8'd1);
      mode = 3'd2; va = 8'd100; vb = 8'd102;
      @(negedge clk);
      chk("R9", dout, 8'd100);
      @(negedge clk);
      chk("R9", dout, 8'd101);
      mode = 3'd4; va = 8'd1; vb = 8'd2;
      @(negedge clk);
      chk("R9", dout, 8'd1);
      @(negedge clk);
      chk("R7", dout, 8'd2);
      @(negedge clk);
      chk("R7", dout, 8'd1);
      mode = 3'd0;
      @(negedge clk);
      chk("R9", dout, 8'd0);
      @(negedge clk);
      chk("R9", dout, 8'd1);
      @(negedge clk);
      chk("R1", dout, 8'd2);

      // R8 reset in mid-run
      rst = 1'b1;
      @(negedge clk);
      chk("R8", dout, 8'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R8", dout, 8'd1);

      // R8 reset into the outside pattern picks its first value
      mode = 3'd3; va = 8'd0; vb = 8'd9; rst = 1'b1;
      @(negedge clk);
      chk("R8", dout, 8'd10);
      rst = 1'b0;

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule